// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip sink for a stream of 32-bit trace words. While capture is switched on, each valid word on the trace input is written into an internal RAM at the write pointer, and the pointer wraps around the RAM so that the newest words overwrite the oldest. A sticky flag reports that the RAM has wrapped at least once. Software reaches the RAM through a register bus. One data register stores a word and advances the write pointer. Another returns the word at the read pointer and advances that pointer. Both pointers can also be loaded directly.

Capture can be ended in two ways. In the first, a trigger pulse arms a post-trigger counter, and capture halts once that many further words are stored. In the second, software requests a flush, the upstream source acknowledges it, and capture halts if stop-on-flush is selected. A stopped status bit reports either halt. Re-enabling capture clears the stopped state. Because trace arrives in four-word frames, a write pointer at rest that is not a multiple of four shows that capture stopped in the middle of a frame.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, the read pointer, write pointer, wrap flag, capture enable, trigger count, stopped bit and pending flush all read 0, and `flush_req` is low.
- R2: A read of offset 0x004 returns the RAM depth in words (the DEPTH parameter, a power of two).
- R3: A bus write to offset 0x024 stores the data word at the write pointer and advances the pointer by one, modulo the depth. Offsets 0x014 (read pointer) and 0x018 (write pointer) read back the pointers in word units. A write to either offset loads that pointer from the low bits of the data.
- R4: A bus read of offset 0x010 returns the RAM word at the read pointer in the same cycle and advances the read pointer by one, wrapping from DEPTH-1 to 0.
- R5: When bit 0 of the control register (offset 0x020) is 1 and the block is not stopped, every cycle with `trc_valid` high stores `trc_data` at the write pointer and advances it. When bit 0 is 0, trace words have no effect on the RAM or the pointer.
- R6: Bit 0 of the status register (offset 0x00C) becomes 1 when any store advances the write pointer from DEPTH-1 to 0. It stays 1 until the write pointer is loaded through offset 0x018.
- R7: With bit 13 of the formatter control register (offset 0x304) set, a `trc_trigger` pulse during active capture loads the count held at offset 0x01C. Capture stops after that many further trace words are stored. A count of 0 stops capture in the trigger cycle, and a word presented in that cycle is still stored. While stopped, bit 1 of the formatter status register (offset 0x300) reads 1.
- R8: When bit 13 of offset 0x304 is 0, `trc_trigger` has no effect.
- R9: Writing offset 0x304 with bit 6 set raises `flush_req`, and bit 6 reads back as 1 until a cycle with `flush_done` high clears it. If bit 12 was set when that acknowledge arrives, capture stops. Bits 0, 12 and 13 read back as written.
- R10: Writing control bit 0 as 1 while capture is off clears the stopped state and disarms the trigger.
- R11: A trace word that arrives in the same cycle as a bus write to offset 0x024 or offset 0x018 is dropped. The bus access takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid in the cycle of the read |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trc_trigger | input | 1 | Trigger event |
| flush_req | output | 1 | Flush requested from the trace source |
| flush_done | input | 1 | Flush acknowledge from the trace source |

## Verification
Read data is combinational, so a read is due in the same cycle as its strobe and is sampled one time unit after the inputs settle, before the next rising edge. Every other effect (pointer moves, the wrap flag, the stopped bit, a raised or cleared `flush_req`) appears from the first edge after the stimulus. The behavioural model is therefore updated at that edge, and the outputs of the next cycle are compared against it. `flush_req` is compared in every cycle, and each register read is compared against the model state of that cycle.

// File: rtl/trs_pkg.sv
// Shared constants for the circular trace capture buffer.
// Assumes a byte-addressed register bus of 12 address bits and 32-bit data.
package trs_pkg;
    localparam int ADDR_W = 12;
    localparam int REG_W  = 32;
    typedef logic [ADDR_W-1:0] trs_addr_t;

    localparam trs_addr_t OFS_DEPTH  = 12'h004;
    localparam trs_addr_t OFS_STATUS = 12'h00C;
    localparam trs_addr_t OFS_RDATA  = 12'h010;
    localparam trs_addr_t OFS_RPTR   = 12'h014;
    localparam trs_addr_t OFS_WPTR   = 12'h018;
    localparam trs_addr_t OFS_TCNT   = 12'h01C;
    localparam trs_addr_t OFS_CTRL   = 12'h020;
    localparam trs_addr_t OFS_WDATA  = 12'h024;
    localparam trs_addr_t OFS_FSTAT  = 12'h300;
    localparam trs_addr_t OFS_FCTRL  = 12'h304;

    // bit positions in the formatter control and status registers
    localparam int FC_EN       = 0;
    localparam int FC_FLUSH    = 6;
    localparam int FC_STOP_FL  = 12;
    localparam int FC_STOP_TRG = 13;
    localparam int FS_STOPPED  = 1;
endpackage

// File: rtl/trs_ring_ram.sv
// Circular word RAM with a write pointer, a read pointer and a sticky wrap flag.
// Assumes DEPTH is a power of two. A store and a write-pointer load never
// occur together, and neither do a read advance and a read-pointer load.
module trs_ring_ram #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_en,
    input  logic [W-1:0]  st_data,
    input  logic          wp_load,
    input  logic          rp_load,
    input  logic [PW-1:0] load_val,
    input  logic          rd_adv,
    output logic [W-1:0]  rd_word,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic          full
);
    logic [W-1:0] mem [DEPTH];

    // storage array written at the write pointer
    always_ff @(posedge clk) begin
        if (st_en) mem[wr_ptr] <= st_data;
    end

    // write pointer and wrap flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            full   <= 1'b0;
        end else if (wp_load) begin
            wr_ptr <= load_val;
            full   <= 1'b0;
        end else if (st_en) begin
            wr_ptr <= wr_ptr + PW'(1);
            if (wr_ptr == PW'(DEPTH - 1)) full <= 1'b1;
        end
    end

    // read pointer
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_ptr <= '0;
        else if (rp_load) rd_ptr <= load_val;
        else if (rd_adv)  rd_ptr <= rd_ptr + PW'(1);
    end

    assign rd_word = mem[rd_ptr];

    p_wptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=> wr_ptr == $past(wr_ptr) + PW'(1));
    p_word_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=> mem[$past(wr_ptr)] == $past(st_data));
    p_rptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |=> rd_ptr == $past(rd_ptr) + PW'(1));
    p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full && !wp_load |=> full);
endmodule

// File: rtl/trs_stop_ctrl.sv
// Capture enable, post-trigger counter, flush handshake and stopped state.
// Assumes word_stored is high only for trace words stored during active capture.
module trs_stop_ctrl #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             ctrl_wbit,
    input  logic             tcnt_we,
    input  logic [CNT_W-1:0] tcnt_wval,
    input  logic             fctl_we,
    input  logic [3:0]       fctl_wbits,   // {stop_trg, stop_fl, flush, en}
    input  logic             trc_trigger,
    input  logic             word_stored,
    input  logic             flush_done,
    output logic             cap_on,
    output logic             cap_en,
    output logic             stopped,
    output logic             flush_pend,
    output logic [CNT_W-1:0] tcnt,
    output logic             fc_en,
    output logic             fc_stop_fl,
    output logic             fc_stop_trg
);
    logic             trig_seen;
    logic [CNT_W-1:0] remain;
    logic             restart, trig_evt, count_evt, stop_now;

    assign cap_on    = cap_en && !stopped;
    assign restart   = ctrl_we && ctrl_wbit && !cap_en;
    assign trig_evt  = trc_trigger && cap_on && fc_stop_trg && !trig_seen;
    assign count_evt = trig_seen && word_stored;
    assign stop_now  = (trig_evt && tcnt == '0)
                     || (count_evt && remain == CNT_W'(1))
                     || (flush_done && flush_pend && fc_stop_fl);

    // software-owned configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_en      <= 1'b0;
            tcnt        <= '0;
            fc_en       <= 1'b0;
            fc_stop_fl  <= 1'b0;
            fc_stop_trg <= 1'b0;
        end else begin
            if (ctrl_we) cap_en <= ctrl_wbit;
            if (tcnt_we) tcnt <= tcnt_wval;
            if (fctl_we) begin
                fc_en       <= fctl_wbits[0];
                fc_stop_fl  <= fctl_wbits[2];
                fc_stop_trg <= fctl_wbits[3];
            end
        end
    end

    // trigger arming and post-trigger countdown
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            trig_seen <= 1'b0;
            remain    <= '0;
        end else if (trig_evt) begin
            trig_seen <= 1'b1;
            remain    <= tcnt;
        end else if (count_evt) begin
            remain <= remain - CNT_W'(1);
        end
    end

    // stopped state, cleared only by a restart
    always_ff @(posedge clk) begin
        if (!rst_n)        stopped <= 1'b0;
        else if (restart)  stopped <= 1'b0;
        else if (stop_now) stopped <= 1'b1;
    end

    // manual flush request, set by software and cleared by the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)                         flush_pend <= 1'b0;
        else if (fctl_we && fctl_wbits[1]) flush_pend <= 1'b1;
        else if (flush_done)               flush_pend <= 1'b0;
    end

    p_flush_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pend && flush_done && !fctl_we |=> !flush_pend);
    p_flush_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pend && flush_done && fc_stop_fl && !ctrl_we |=> stopped);
    p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stopped && !ctrl_we |=> stopped);
    p_no_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_stop_trg && !trig_seen |=> !trig_seen);
    p_stopped_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !word_stored);
endmodule

// File: rtl/trace_ring_sink.sv
// Circular trace capture buffer: register decode, store arbitration and read mux.
// Assumes at most one of bus_wr and bus_rd is high in any cycle.
module trace_ring_sink #(
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [trs_pkg::ADDR_W-1:0] bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [trs_pkg::REG_W-1:0]  bus_wdata,
    output logic [trs_pkg::REG_W-1:0]  bus_rdata,
    input  logic                       trc_valid,
    input  logic [trs_pkg::REG_W-1:0]  trc_data,
    input  logic                       trc_trigger,
    output logic                       flush_req,
    input  logic                       flush_done
);
    import trs_pkg::*;

    logic             bus_st, wp_load, rp_load, rd_adv, trc_st, st_en;
    logic [REG_W-1:0] st_data, rd_word, tcnt;
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             full, cap_on, cap_en, stopped, flush_pend;
    logic             fc_en, fc_stop_fl, fc_stop_trg;

    assign bus_st  = bus_wr && bus_addr == OFS_WDATA;
    assign wp_load = bus_wr && bus_addr == OFS_WPTR;
    assign rp_load = bus_wr && bus_addr == OFS_RPTR;
    assign rd_adv  = bus_rd && bus_addr == OFS_RDATA;
    assign trc_st  = trc_valid && cap_on && !bus_st && !wp_load;
    assign st_en   = bus_st || trc_st;
    assign st_data = bus_st ? bus_wdata : trc_data;

    trs_ring_ram #(.DEPTH(DEPTH), .W(REG_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .st_en(st_en), .st_data(st_data),
        .wp_load(wp_load), .rp_load(rp_load), .load_val(bus_wdata[PW-1:0]),
        .rd_adv(rd_adv), .rd_word(rd_word),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full)
    );

    trs_stop_ctrl #(.CNT_W(REG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(bus_wr && bus_addr == OFS_CTRL), .ctrl_wbit(bus_wdata[0]),
        .tcnt_we(bus_wr && bus_addr == OFS_TCNT), .tcnt_wval(bus_wdata),
        .fctl_we(bus_wr && bus_addr == OFS_FCTRL),
        .fctl_wbits({bus_wdata[FC_STOP_TRG], bus_wdata[FC_STOP_FL],
                     bus_wdata[FC_FLUSH], bus_wdata[FC_EN]}),
        .trc_trigger(trc_trigger), .word_stored(trc_st), .flush_done(flush_done),
        .cap_on(cap_on), .cap_en(cap_en), .stopped(stopped), .flush_pend(flush_pend),
        .tcnt(tcnt), .fc_en(fc_en), .fc_stop_fl(fc_stop_fl), .fc_stop_trg(fc_stop_trg)
    );

    assign flush_req = flush_pend;

    // register read multiplexer, combinational in the cycle of the read
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DEPTH:  bus_rdata = REG_W'(DEPTH);
            OFS_STATUS: bus_rdata[0] = full;
            OFS_RDATA:  bus_rdata = rd_word;
            OFS_RPTR:   bus_rdata = REG_W'(rd_ptr);
            OFS_WPTR:   bus_rdata = REG_W'(wr_ptr);
            OFS_TCNT:   bus_rdata = tcnt;
            OFS_CTRL:   bus_rdata[0] = cap_en;
            OFS_FSTAT:  bus_rdata[FS_STOPPED] = stopped;
            OFS_FCTRL: begin
                bus_rdata[FC_EN]       = fc_en;
                bus_rdata[FC_FLUSH]    = flush_pend;
                bus_rdata[FC_STOP_FL]  = fc_stop_fl;
                bus_rdata[FC_STOP_TRG] = fc_stop_trg;
            end
            default: bus_rdata = '0;
        endcase
    end

    p_bus_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trc_valid && bus_st |=> wr_ptr == $past(wr_ptr) + PW'(1));
endmodule

// File: tb/trace_ring_sink_bench.sv
`timescale 1ns/1ps
module trace_ring_sink_bench;
    import trs_pkg::*;
    localparam int D = 16;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [11:0] b_addr = '0;
    logic        b_wr = 1'b0, b_rd = 1'b0, t_valid = 1'b0, t_trig = 1'b0, f_done = 1'b0;
    logic [31:0] b_wdata = '0, t_data = '0, bus_rdata;
    logic        flush_req;

    trace_ring_sink #(.DEPTH(D)) u_trace_ring_sink (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
        .bus_wdata(b_wdata), .bus_rdata(bus_rdata), .trc_valid(t_valid),
        .trc_data(t_data), .trc_trigger(t_trig), .flush_req(flush_req),
        .flush_done(f_done)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 0;

    // behavioural reference state
    int unsigned mem_m [D];
    int  wp = 0, rp = 0, rem = 0;
    int unsigned tcnt = 0;
    bit full = 0, cap = 0, stopped = 0, tseen = 0, fen = 0, sfl = 0, strg = 0, fpend = 0;

    function automatic int unsigned exp_read(logic [11:0] a);
        case (a)
            OFS_DEPTH:  return D;
            OFS_STATUS: return {31'd0, full};
            OFS_RDATA:  return mem_m[rp];
            OFS_RPTR:   return rp;
            OFS_WPTR:   return wp;
            OFS_TCNT:   return tcnt;
            OFS_CTRL:   return {31'd0, cap};
            OFS_FSTAT:  return stopped ? 32'h2 : 32'h0;
            OFS_FCTRL:  return (32'(strg) << 13) | (32'(sfl) << 12) | (32'(fpend) << 6) | 32'(fen);
            default:    return 0;
        endcase
    endfunction

    task automatic model_update();
        bit act = cap && !stopped;
        bit bst = b_wr && b_addr == OFS_WDATA;
        bit wpl = b_wr && b_addr == OFS_WPTR;
        bit tst = t_valid && act && !bst && !wpl;
        int nwp = wp, nrp = rp, nrem = rem;
        bit nfull = full, nstop = stopped, ntseen = tseen, nfp = fpend;
        if (bst || tst) begin
            mem_m[wp] = bst ? b_wdata : t_data;
            if (wp == D - 1) nfull = 1;
            nwp = (wp + 1) % D;
        end
        if (t_trig && act && strg && !tseen) begin
            ntseen = 1; nrem = int'(tcnt);
            if (tcnt == 0) nstop = 1;
        end else if (tseen && tst) begin
            nrem = rem - 1;
            if (rem == 1) nstop = 1;
        end
        if (f_done && fpend) begin
            nfp = 0;
            if (sfl) nstop = 1;
        end
        if (b_rd && b_addr == OFS_RDATA) nrp = (rp + 1) % D;
        if (b_wr) begin
            case (b_addr)
                OFS_RPTR: nrp = int'(b_wdata % D);
                OFS_WPTR: begin nwp = int'(b_wdata % D); nfull = 0; end
                OFS_TCNT: tcnt = b_wdata;
                OFS_CTRL: begin
                    if (b_wdata[0] && !cap) begin nstop = 0; ntseen = 0; nrem = 0; end
                    cap = b_wdata[0];
                end
                OFS_FCTRL: begin
                    fen = b_wdata[0]; sfl = b_wdata[12]; strg = b_wdata[13];
                    if (b_wdata[6]) nfp = 1;
                end
                default: ;
            endcase
        end
        wp = nwp; rp = nrp; rem = nrem; full = nfull;
        stopped = nstop; tseen = ntseen; fpend = nfp;
    endtask

    // one clock: compare outputs against the model, then advance the model at the edge
    task automatic step(string tag);
        int unsigned e;
        #1;
        checks++;
        if (flush_req !== fpend) begin
            fails++;
            $display("FAIL R9 flush_req got %0b expected %0b", flush_req, fpend);
        end
        if (b_rd) begin
            checks++;
            e = exp_read(b_addr);
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s read 0x%03h got 0x%08h expected 0x%08h", tag, b_addr, bus_rdata, e);
            end
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
        b_wr = 0; b_rd = 0; t_valid = 0; t_trig = 0; f_done = 0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
        b_addr = a; b_wdata = d; b_wr = 1; step(tag);
    endtask
    task automatic rd(logic [11:0] a, string tag);
        b_addr = a; b_rd = 1; step(tag);
    endtask
    task automatic trc(bit v, logic [31:0] d, bit trg, string tag);
        t_valid = v; t_data = d; t_trig = trg; step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        foreach (mem_m[i]) mem_m[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(OFS_STATUS, "R1"); rd(OFS_WPTR, "R1"); rd(OFS_RPTR, "R1");
        rd(OFS_CTRL, "R1"); rd(OFS_FSTAT, "R1"); rd(OFS_FCTRL, "R1"); rd(OFS_TCNT, "R1");
        // R2 depth
        rd(OFS_DEPTH, "R2");
        // R3 fill the whole RAM through the data register, R6 wrap flag
        wr(OFS_WPTR, 0, "R3");
        for (int i = 0; i < D; i++) wr(OFS_WDATA, 32'h100 + 3 * i, "R3");
        rd(OFS_WPTR, "R3"); rd(OFS_STATUS, "R6");
        wr(OFS_WPTR, 5, "R6"); rd(OFS_STATUS, "R6");
        wr(OFS_WDATA, 32'hAAAA_5555, "R3"); rd(OFS_WPTR, "R3");
        // R4 read-back with wrap
        wr(OFS_RPTR, 4, "R4");
        for (int i = 0; i < 3; i++) rd(OFS_RDATA, "R4");
        rd(OFS_RPTR, "R4");
        wr(OFS_RPTR, D - 1, "R4"); rd(OFS_RDATA, "R4"); rd(OFS_RDATA, "R4"); rd(OFS_RPTR, "R4");
        // R5 capture off: trace ignored
        trc(1, 32'hDEAD_0001, 0, "R5"); trc(1, 32'hDEAD_0002, 0, "R5");
        rd(OFS_WPTR, "R5");
        // R5 capture on, words with gaps
        wr(OFS_CTRL, 1, "R5");
        trc(1, 32'hC0DE_0000, 0, "R5"); trc(0, 0, 0, "R5");
        trc(1, 32'hC0DE_0001, 0, "R5"); trc(1, 32'hC0DE_0002, 0, "R5");
        rd(OFS_WPTR, "R5");
        wr(OFS_RPTR, 6, "R5");
        for (int i = 0; i < 3; i++) rd(OFS_RDATA, "R5");
        // R11 bus store and pointer load beat trace words
        t_valid = 1; t_data = 32'hBAD0_0001; b_addr = OFS_WDATA; b_wdata = 32'h600D_0001; b_wr = 1; step("R11");
        rd(OFS_WPTR, "R11");
        t_valid = 1; t_data = 32'hBAD0_0002; b_addr = OFS_WPTR; b_wdata = 2; b_wr = 1; step("R11");
        rd(OFS_WPTR, "R11");
        wr(OFS_RPTR, 9, "R11"); rd(OFS_RDATA, "R11");
        // R6 wrap via trace
        wr(OFS_WPTR, D - 2, "R6"); rd(OFS_STATUS, "R6");
        for (int i = 0; i < 3; i++) trc(1, 32'hF00 + i, 0, "R6");
        rd(OFS_STATUS, "R6"); rd(OFS_WPTR, "R6");
        // R7 stop after four post-trigger words
        wr(OFS_CTRL, 0, "R7"); wr(OFS_WPTR, 0, "R7"); wr(OFS_TCNT, 4, "R7");
        wr(OFS_FCTRL, 32'h2001, "R7"); rd(OFS_FCTRL, "R9"); wr(OFS_CTRL, 1, "R7");
        trc(1, 32'h1, 0, "R7"); trc(1, 32'h2, 0, "R7");
        trc(1, 32'h3, 1, "R7");
        for (int i = 0; i < 3; i++) trc(1, 32'h10 + i, 0, "R7");
        rd(OFS_FSTAT, "R7");
        for (int i = 0; i < 3; i++) trc(1, 32'h20 + i, 0, "R7");
        rd(OFS_FSTAT, "R7"); rd(OFS_WPTR, "R7");
        // R10 restart clears stopped, then R7 count of zero
        wr(OFS_CTRL, 0, "R10"); rd(OFS_FSTAT, "R10");
        wr(OFS_CTRL, 1, "R10"); rd(OFS_FSTAT, "R10");
        wr(OFS_TCNT, 0, "R7");
        trc(1, 32'h30, 1, "R7"); rd(OFS_FSTAT, "R7"); rd(OFS_WPTR, "R7");
        trc(1, 32'h31, 0, "R7"); rd(OFS_WPTR, "R7");
        // R8 trigger ignored without stop-on-trigger
        wr(OFS_CTRL, 0, "R8"); wr(OFS_FCTRL, 32'h1, "R8"); wr(OFS_CTRL, 1, "R8");
        trc(1, 32'h40, 1, "R8"); trc(1, 32'h41, 0, "R8"); trc(1, 32'h42, 1, "R8");
        rd(OFS_FSTAT, "R8"); rd(OFS_WPTR, "R8");
        // R9 flush with stop-on-flush
        wr(OFS_FCTRL, 32'h1041, "R9"); rd(OFS_FCTRL, "R9");
        trc(1, 32'h50, 0, "R9"); rd(OFS_FSTAT, "R9");
        f_done = 1; step("R9");
        rd(OFS_FCTRL, "R9"); rd(OFS_FSTAT, "R9");
        trc(1, 32'h51, 0, "R9"); rd(OFS_WPTR, "R9");
        // R9 flush without stop-on-flush
        wr(OFS_CTRL, 0, "R9"); wr(OFS_CTRL, 1, "R9");
        wr(OFS_FCTRL, 32'h0041, "R9"); trc(0, 0, 0, "R9");
        f_done = 1; step("R9");
        rd(OFS_FSTAT, "R9"); rd(OFS_FCTRL, "R9");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule